// File: doc/BRIEF.md
# ZQ Calibration Scheduler

This block sits on the controller side of a DDR3 channel. It decides when each rank needs an impedance calibration and issues it. A calibration is either the long form (command address bit A10 high) or the short form (A10 low). It then keeps the channel quiet for the calibration window before handing the channel back. All ranks on the channel share one calibration resistor, so only one rank is ever being calibrated.

Three events create work:
- Reset leaves every rank owing a long calibration. The first long calibration of a rank after reset uses the initialisation window. Any later long calibration uses the shorter operating window.
- A free-running period counter queues a short calibration on every rank each time it expires.
- A self-refresh exit on a rank queues a long calibration for that rank. That calibration is held back until the exit delay has passed.

The scheduler raises a channel request and waits for the main controller's grant before it issues a command. It also waits until all banks report precharged and the precharge time has passed since the last precharge. While a window runs, it reports busy and holds clock-enable high and on-die termination off.

Top module: `zq_sched`

## Requirements
- R1: After reset every rank owes a long calibration (A10 = 1). Each rank's first long calibration holds busy for T_ZQINIT + 1 cycles: the command cycle plus T_ZQINIT quiet cycles.
- R2: Every later long calibration of a rank holds busy for T_ZQOPER + 1 cycles.
- R3: Each time the period counter expires (every ZQCS_INTERVAL cycles), a short calibration (A10 = 0) is queued on every rank. A short calibration holds busy for T_ZQCS + 1 cycles.
- R4: `zq_cmd_valid` pulses for one cycle, and busy is high in that cycle. No other command is issued while busy is high. `chan_req` is high whenever busy is high, and busy drops one cycle after the window count reaches zero.
- R5: A command is issued only on an edge where `chan_gnt` and `all_banks_idle` are high, `pre_issued` is low, and at least T_RP edges have passed since the last `pre_issued`.
- R6: A pulse on `sr_exit[r]` queues a long calibration for rank r. That calibration is not issued until T_XS cycles after the pulse.
- R7: `cke_hold` and `odt_off` are high in every cycle in which busy is high.
- R8: Ranks are calibrated one at a time. The lowest-numbered rank with any owed calibration goes first. If that rank owes a long calibration, the long form is issued for it.
- R9: Issuing a long calibration for a rank also clears any short calibration owed by that rank. If a new request for a rank arrives on the same edge as that rank's issue, the request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_gnt | input | 1 | Main controller grants the channel |
| all_banks_idle | input | 1 | All banks are precharged |
| pre_issued | input | 1 | A precharge command is issued this cycle |
| sr_exit | input | NUM_RANKS | Per-rank self-refresh exit pulse |
| chan_req | output | 1 | Channel requested or held |
| zq_busy | output | 1 | Calibration window in progress |
| zq_cmd_valid | output | 1 | Calibration command on the bus this cycle |
| zq_cmd_a10 | output | 1 | Command form: 1 = long, 0 = short |
| zq_cmd_rank | output | RANK_W | Target rank of the command |
| cke_hold | output | 1 | Forces clock-enable high |
| odt_off | output | 1 | Forces on-die termination off |

## Verification
Two events can land on the edge where a command is issued. The first is the period counter expiring while a short request for the same rank is being cleared. The second is a precharge or self-refresh exit arriving while the entry checks are being evaluated. The bench provokes the first directly: it holds the grant low until its reference model shows the period counter at zero with a request waiting, then grants on that cycle. Precharge, self-refresh exit, grant and bank-idle inputs are also driven at random. A behavioural model predicts every output on every clock, so a dropped re-queue, or a command slipping past a fresh precharge or exit, shows up as a mismatch on the next sampled cycle.

// File: rtl/zq_pkg.sv
package zq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WIN  = 2'd2
  } zq_state_e;
endpackage

// File: rtl/zq_entry_timers.sv
module zq_entry_timers #(
  parameter int NUM_RANKS     = 4,
  parameter int T_RP          = 5,
  parameter int T_XS          = 12,
  parameter int ZQCS_INTERVAL = 400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pre_issued,
  input  logic [NUM_RANKS-1:0] sr_exit,
  output logic                 trp_ok,
  output logic [NUM_RANKS-1:0] xs_ok,
  output logic                 per_tick
);
  localparam int RPW = $clog2(T_RP + 1);
  localparam int XSW = $clog2(T_XS + 1);
  localparam int PW  = $clog2(ZQCS_INTERVAL);

  // precharge-to-calibration timer, saturates at T_RP
  logic [RPW-1:0] rp_q, rp_d;
  logic           rp_en;

  always_comb begin
    rp_en = pre_issued || (rp_q != RPW'(T_RP));
    rp_d  = pre_issued ? '0 : rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rp_q <= RPW'(T_RP);
    else if (rp_en) rp_q <= rp_d;
  end

  assign trp_ok = (rp_q == RPW'(T_RP)) && !pre_issued;

  // per-rank self-refresh exit delay
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_xs
    logic [XSW-1:0] xs_q, xs_d;
    logic           xs_en;

    always_comb begin
      xs_en = sr_exit[g] || (xs_q != '0);
      xs_d  = sr_exit[g] ? XSW'(T_XS) : xs_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     xs_q <= '0;
      else if (xs_en) xs_q <= xs_d;
    end

    assign xs_ok[g] = (xs_q == '0) && !sr_exit[g];
  end

  // periodic short-calibration counter
  logic [PW-1:0] per_q, per_d;

  assign per_tick = (per_q == '0);

  always_comb begin
    per_d = per_tick ? PW'(ZQCS_INTERVAL - 1) : per_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= PW'(ZQCS_INTERVAL - 1);
    else        per_q <= per_d;
  end
endmodule

// File: rtl/zq_pend_arb.sv
module zq_pend_arb #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RANKS-1:0] set_long,
  input  logic                 set_short,
  input  logic                 take_sel,
  output logic                 any_pend,
  output logic [RANK_W-1:0]    sel_rank,
  output logic                 sel_long,
  output logic                 sel_first
);
  logic [NUM_RANKS-1:0] long_q, long_d;
  logic [NUM_RANKS-1:0] short_q, short_d;
  logic [NUM_RANKS-1:0] done_q, done_d;
  logic [NUM_RANKS-1:0] pend, clr_vec;

  assign pend     = long_q | short_q;
  assign any_pend = |pend;

  // lowest pending rank wins
  always_comb begin
    sel_rank = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (pend[i]) sel_rank = RANK_W'(i);
    end
  end

  assign sel_long  = long_q[sel_rank];
  assign sel_first = !done_q[sel_rank];

  // clear on issue first, new requests win over the clear
  always_comb begin
    clr_vec = '0;
    if (take_sel) clr_vec[sel_rank] = 1'b1;
    long_d  = (long_q & ~(clr_vec & {NUM_RANKS{sel_long}})) | set_long;
    short_d = (short_q & ~clr_vec) | {NUM_RANKS{set_short}};
    done_d  = done_q | (clr_vec & {NUM_RANKS{sel_long}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q  <= '1;
      short_q <= '0;
      done_q  <= '0;
    end else begin
      long_q  <= long_d;
      short_q <= short_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/zq_sched.sv
module zq_sched
  import zq_pkg::*;
#(
  parameter int NUM_RANKS     = 4,
  parameter int T_ZQINIT      = 64,
  parameter int T_ZQOPER      = 32,
  parameter int T_ZQCS        = 8,
  parameter int T_RP          = 5,
  parameter int T_XS          = 12,
  parameter int ZQCS_INTERVAL = 400,
  parameter int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_gnt,
  input  logic                 all_banks_idle,
  input  logic                 pre_issued,
  input  logic [NUM_RANKS-1:0] sr_exit,
  output logic                 chan_req,
  output logic                 zq_busy,
  output logic                 zq_cmd_valid,
  output logic                 zq_cmd_a10,
  output logic [RANK_W-1:0]    zq_cmd_rank,
  output logic                 cke_hold,
  output logic                 odt_off
);
  localparam int MAX_A = (T_ZQINIT > T_ZQOPER) ? T_ZQINIT : T_ZQOPER;
  localparam int MAX_W = (MAX_A > T_ZQCS) ? MAX_A : T_ZQCS;
  localparam int WW    = $clog2(MAX_W + 1);

  logic                 trp_ok, per_tick;
  logic [NUM_RANKS-1:0] xs_ok;
  logic                 any_pend, sel_long, sel_first;
  logic [RANK_W-1:0]    sel_rank;
  logic                 go;

  zq_entry_timers #(
    .NUM_RANKS(NUM_RANKS), .T_RP(T_RP), .T_XS(T_XS), .ZQCS_INTERVAL(ZQCS_INTERVAL)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .pre_issued(pre_issued), .sr_exit(sr_exit),
    .trp_ok(trp_ok), .xs_ok(xs_ok), .per_tick(per_tick)
  );

  zq_pend_arb #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .set_long(sr_exit), .set_short(per_tick),
    .take_sel(go), .any_pend(any_pend), .sel_rank(sel_rank),
    .sel_long(sel_long), .sel_first(sel_first)
  );

  zq_state_e      state_q, state_d;
  logic [WW-1:0]  cnt_q, cnt_d, win_len;
  logic           cnt_en;
  logic           cmd_q, a10_q, hold_q;
  logic [RANK_W-1:0] rank_q;

  always_comb begin
    if (!sel_long)     win_len = WW'(T_ZQCS);
    else if (sel_first) win_len = WW'(T_ZQINIT);
    else               win_len = WW'(T_ZQOPER);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    go      = 1'b0;
    case (state_q)
      ST_IDLE: if (any_pend) state_d = ST_REQ;
      ST_REQ: begin
        if (any_pend && chan_gnt && all_banks_idle && trp_ok && xs_ok[sel_rank]) begin
          go      = 1'b1;
          state_d = ST_WIN;
          cnt_d   = win_len;
          cnt_en  = 1'b1;
        end
      end
      ST_WIN: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= 1'b0;
      a10_q   <= 1'b0;
      rank_q  <= '0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      cmd_q   <= go;
      hold_q  <= (state_d == ST_WIN);
      if (go) begin
        a10_q  <= sel_long;
        rank_q <= sel_rank;
      end
    end
  end

  assign chan_req     = (state_q != ST_IDLE);
  assign zq_busy      = (state_q == ST_WIN);
  assign zq_cmd_valid = cmd_q;
  assign zq_cmd_a10   = a10_q;
  assign zq_cmd_rank  = rank_q;
  assign cke_hold     = hold_q;
  assign odt_off      = hold_q;
endmodule

// File: rtl/zq_sched_chk.sv
module zq_sched_chk #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chan_gnt,
  input logic                 all_banks_idle,
  input logic                 pre_issued,
  input logic                 chan_req,
  input logic                 zq_busy,
  input logic                 zq_cmd_valid,
  input logic [RANK_W-1:0]    zq_cmd_rank,
  input logic                 cke_hold,
  input logic                 odt_off
);
  AST_CMD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    zq_cmd_valid |-> zq_busy); // R4

  AST_CMD_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    zq_cmd_valid |-> !$past(zq_busy)); // R4

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    zq_cmd_valid |=> !zq_cmd_valid); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    zq_busy |-> chan_req); // R4

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    zq_cmd_valid |-> $past(chan_gnt && all_banks_idle && !pre_issued)); // R5

  AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    zq_busy |-> (cke_hold && odt_off)); // R7

  AST_RANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    zq_cmd_valid |-> (int'(zq_cmd_rank) < NUM_RANKS)); // R8
endmodule

bind zq_sched zq_sched_chk #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_gnt(chan_gnt), .all_banks_idle(all_banks_idle),
  .pre_issued(pre_issued), .chan_req(chan_req), .zq_busy(zq_busy),
  .zq_cmd_valid(zq_cmd_valid), .zq_cmd_rank(zq_cmd_rank),
  .cke_hold(cke_hold), .odt_off(odt_off)
);

// File: tb/zq_sched_tb.sv
`timescale 1ns/1ps
module zq_sched_tb_top;
  localparam int NR   = 4;
  localparam int RW   = 2;
  localparam int TINI = 40;
  localparam int TOPR = 20;
  localparam int TCS  = 6;
  localparam int TRP  = 4;
  localparam int TXS  = 10;
  localparam int PER  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_gnt = 1'b0, all_banks_idle = 1'b0, pre_issued = 1'b0;
  logic [NR-1:0] sr_exit = '0;
  logic chan_req, zq_busy, zq_cmd_valid, zq_cmd_a10, cke_hold, odt_off;
  logic [RW-1:0] zq_cmd_rank;

  always #4 clk = ~clk;

  zq_sched #(.NUM_RANKS(NR), .T_ZQINIT(TINI), .T_ZQOPER(TOPR), .T_ZQCS(TCS),
             .T_RP(TRP), .T_XS(TXS), .ZQCS_INTERVAL(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_gnt(chan_gnt), .all_banks_idle(all_banks_idle),
    .pre_issued(pre_issued), .sr_exit(sr_exit), .chan_req(chan_req), .zq_busy(zq_busy),
    .zq_cmd_valid(zq_cmd_valid), .zq_cmd_a10(zq_cmd_a10), .zq_cmd_rank(zq_cmd_rank),
    .cke_hold(cke_hold), .odt_off(odt_off)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle, 1 requesting, 2 window
  int m_st, m_wc, m_cmd, m_a10, m_rank, m_trp, m_per;
  int m_lp[NR], m_sp[NR], m_done[NR], m_xs[NR];
  int sel, w, is_long, tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wc = 0; m_cmd = 0; m_a10 = 0; m_rank = 0;
      m_trp = TRP; m_per = PER - 1;
      for (int r = 0; r < NR; r++) begin
        m_lp[r] = 1; m_sp[r] = 0; m_done[r] = 0; m_xs[r] = 0;
      end
    end else begin
      sel = -1;
      for (int r = NR - 1; r >= 0; r--) if (m_lp[r] != 0 || m_sp[r] != 0) sel = r;
      tick = (m_per == 0) ? 1 : 0;
      m_cmd = 0;
      if (m_st == 0) begin
        if (sel >= 0) m_st = 1;
      end else if (m_st == 1) begin
        if (sel >= 0 && chan_gnt && all_banks_idle && !pre_issued && m_trp >= TRP
            && m_xs[sel] == 0 && !sr_exit[sel]) begin
          is_long = m_lp[sel];
          w = (is_long != 0) ? ((m_done[sel] != 0) ? TOPR : TINI) : TCS;
          if (is_long != 0) begin m_lp[sel] = 0; m_done[sel] = 1; end
          m_sp[sel] = 0;
          m_st = 2; m_wc = w; m_cmd = 1; m_a10 = is_long; m_rank = sel;
        end
      end else begin
        if (m_wc == 0) m_st = 0; else m_wc = m_wc - 1;
      end
      for (int r = 0; r < NR; r++) begin
        if (sr_exit[r]) m_lp[r] = 1;
        if (tick != 0) m_sp[r] = 1;
        m_xs[r] = sr_exit[r] ? TXS : ((m_xs[r] > 0) ? m_xs[r] - 1 : 0);
      end
      m_trp = pre_issued ? 0 : ((m_trp < TRP) ? m_trp + 1 : m_trp);
      m_per = (tick != 0) ? PER - 1 : m_per - 1;
    end
  end

  always @(posedge clk) cyc++;

  // per-cycle comparison against the model, plus directed monitors
  int ncmd = 0, busy_len = 0, last_a10 = 0, last_first = 0, n_short = 0, n_oper = 0;
  int xs_stamp[NR];
  bit xs_armed[NR];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 chan_req", int'(chan_req), (m_st != 0) ? 1 : 0);
      check("R4 zq_busy", int'(zq_busy), (m_st == 2) ? 1 : 0);
      check("R5 R6 R9 zq_cmd_valid", int'(zq_cmd_valid), m_cmd);
      check("R7 cke_hold", int'(cke_hold), (m_st == 2) ? 1 : 0);
      check("R7 odt_off", int'(odt_off), (m_st == 2) ? 1 : 0);
      if (m_cmd != 0) begin
        check("R1 R2 R3 zq_cmd_a10", int'(zq_cmd_a10), m_a10);
        check("R8 zq_cmd_rank", int'(zq_cmd_rank), m_rank);
      end
      if (zq_cmd_valid) begin
        if (ncmd < NR) begin
          check("R1 first commands are long", int'(zq_cmd_a10), 1);
          check("R8 ascending initial order", int'(zq_cmd_rank), ncmd);
        end
        last_first = (ncmd < NR) ? 1 : 0;
        last_a10 = int'(zq_cmd_a10);
        ncmd++;
        if (!zq_cmd_a10) n_short++;
        if (xs_armed[zq_cmd_rank] && xs_stamp[zq_cmd_rank] < cyc) begin
          check("R6 exit delay honoured", (cyc - xs_stamp[zq_cmd_rank] > TXS) ? 1 : 0, 1);
          xs_armed[zq_cmd_rank] = 1'b0;
        end
      end
      if (zq_busy) begin
        busy_len++;
      end else if (busy_len > 0) begin
        if (last_a10 == 0)       check("R3 short window length", busy_len, TCS + 1);
        else if (last_first != 0) check("R1 init window length", busy_len, TINI + 1);
        else begin
          check("R2 operating window length", busy_len, TOPR + 1);
          n_oper++;
        end
        busy_len = 0;
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin xs_armed[r] = 1'b0; xs_stamp[r] = 0; end
    repeat (3) @(negedge clk);
    check("R4 reset chan_req", int'(chan_req), 0);
    check("R4 reset zq_busy", int'(zq_busy), 0);
    check("R4 reset zq_cmd_valid", int'(zq_cmd_valid), 0);
    check("R7 reset cke_hold", int'(cke_hold), 0);
    rst_n = 1'b1;
    chan_gnt = 1'b1; all_banks_idle = 1'b1;
    repeat (400) @(negedge clk);
    // random traffic
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      chan_gnt       = ($urandom % 4) != 0;
      all_banks_idle = ($urandom % 8) != 0;
      pre_issued     = (m_st != 2) && (($urandom % 16) == 0);
      for (int r = 0; r < NR; r++) begin
        sr_exit[r] = (($urandom % 500) == 0);
        if (sr_exit[r]) begin xs_stamp[r] = cyc; xs_armed[r] = 1'b1; end
      end
    end
    // grant exactly on the edge where the period counter expires
    @(negedge clk);
    chan_gnt = 1'b0; all_banks_idle = 1'b1; pre_issued = 1'b0; sr_exit = '0;
    for (int i = 0; i < 2 * PER + 20; i++) begin
      @(negedge clk);
      if (m_st == 1 && m_per == 0) break;
    end
    chan_gnt = 1'b1;
    repeat (600) @(negedge clk);
    check("R3 short calibrations seen", (n_short > 0) ? 1 : 0, 1);
    check("R2 operating windows seen", (n_oper > 0) ? 1 : 0, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule